// File: doc/BRIEF.md
# Population Count Execution Unit

This block is an integer execution unit that returns how many bits are one in a source operand. The operand may be 16, 32 or 64 bits wide. With the count it returns a status flag vector in which only the zero flag depends on the data. Two decode side-band inputs gate the operation. If the feature is not enabled, or the instruction carries a lock prefix, the unit raises an invalid-opcode fault instead of producing a result.

The unit accepts one operation per clock whenever `in_valid` is high. The count comes from a combinational adder tree, so no sequential loop is involved. The result, the flags, `out_valid` and `out_fault` come out of a single register stage and appear exactly one clock after the operation is sampled. Address generation, memory access and register-file writeback belong to the surrounding pipeline.

Top module: `popc_unit`

## Requirements
- R1: For a sampled operation without a fault, `out_result` equals the number of one bits in the low bits of `in_src` selected by the operand size.
- R2: The operand size is encoded on `in_size` as 2'b00 = 16 bits, 2'b01 = 32 bits, 2'b10 = 64 bits and 2'b11 = 64 bits. Bits of `in_src` above the selected size have no effect on the result or the flags.
- R3: The count is zero-extended to 64 bits and overwrites the whole `out_result`. Its largest value is 64, reached by a 64-bit all-ones operand.
- R4: The flag vector `out_flags` is laid out as bit0 carry, bit1 parity, bit2 auxiliary carry, bit3 zero, bit4 sign and bit5 overflow. Every bit except bit3 is zero after any completed operation.
- R5: Flag bit3 (zero) is one exactly when the selected source bits are all zero.
- R6: A sampled operation with `in_feat_en` low raises `out_fault`.
- R7: A sampled operation with `in_lock` high raises `out_fault`.
- R8: When an operation faults, `out_valid` stays low for it, and `out_result` and `out_flags` keep their previous values.
- R9: `out_valid`, `out_result`, `out_flags` and `out_fault` appear exactly one clock after `in_valid` is sampled high. Operations may arrive on back-to-back cycles.
- R10: A synchronous active-low reset clears `out_valid`, `out_fault`, `out_result` and `out_flags`.
- R11: A cycle with `in_valid` low produces `out_valid` and `out_fault` both low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_src | input | 64 | Source operand |
| in_size | input | 2 | Operand size select |
| in_feat_en | input | 1 | Feature enable from decode |
| in_lock | input | 1 | Lock prefix present |
| out_valid | output | 1 | Result and flags valid |
| out_result | output | 64 | Zero-extended count |
| out_flags | output | 6 | Status flag vector |
| out_fault | output | 1 | Invalid-opcode fault |

## Verification
Every output is due one rising edge after the operation is sampled. The bench drives inputs on the falling edge and checks shortly after the next rising edge, so each check looks at the operation driven half a cycle earlier. Operations are streamed with `in_valid` held high, which makes back-to-back issue the normal case. After a fault or an idle cycle, the bench checks that the previously registered result and flags have not changed.

// File: rtl/popc_pkg.sv
// Shared types for the population count unit: operand size codes and flag positions.
// Assumes a six-bit flag vector whose bit order is fixed by the consumers downstream.
package popc_pkg;
    typedef enum logic [1:0] {
        OPSZ_16   = 2'b00,
        OPSZ_32   = 2'b01,
        OPSZ_64   = 2'b10,
        OPSZ_RSVD = 2'b11
    } opsz_e;

    localparam int FLAG_W  = 6;
    localparam int FLG_CF  = 0;
    localparam int FLG_PF  = 1;
    localparam int FLG_AF  = 2;
    localparam int FLG_ZF  = 3;
    localparam int FLG_SF  = 4;
    localparam int FLG_OF  = 5;
endpackage

// File: rtl/popc_mask.sv
// Clears the source bits that lie above the selected operand size.
// Assumes DATA_W is at least 64. The reserved size code selects the full width.
module popc_mask
    import popc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src,
    input  opsz_e             size,
    output logic [DATA_W-1:0] masked
);
    localparam int SEL_W = $clog2(DATA_W + 1);

    logic [SEL_W-1:0] keep_w;

    // Purpose: turn the size code into a count of low bits to keep.
    always_comb begin
        case (size)
            OPSZ_16: keep_w = SEL_W'(16);
            OPSZ_32: keep_w = SEL_W'(32);
            default: keep_w = SEL_W'(DATA_W);
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign masked[i] = src[i] & (SEL_W'(i) < keep_w);
    end
endmodule

// File: rtl/popc_tree.sv
// Balanced adder tree that sums single-bit leaves into a count.
// Assumes LEAVES is a power of two. The tree has log2(LEAVES) adder levels and no state.
module popc_tree #(
    parameter int LEAVES = 64,
    parameter int CNT_W  = $clog2(LEAVES + 1)
) (
    input  logic [LEAVES-1:0] bits,
    output logic [CNT_W-1:0]  count
);
    localparam int LEVELS = $clog2(LEAVES);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int NODES = LEAVES >> l;
        logic [CNT_W-1:0] node [NODES];
        for (genvar n = 0; n < NODES; n++) begin : g_node
            if (l == 0) begin : g_leaf
                assign node[n] = CNT_W'(bits[n]);
            end else begin : g_sum
                assign node[n] = g_lvl[l-1].node[2*n] + g_lvl[l-1].node[2*n+1];
            end
        end
    end

    assign count = g_lvl[LEVELS].node[0];
endmodule

// File: rtl/popc_gate.sv
// Decodes the side-band inputs into an invalid-opcode condition.
// Assumes both inputs are already qualified by the decode stage.
module popc_gate (
    input  logic feat_en,
    input  logic lock,
    output logic bad_op
);
    // Purpose: a disabled feature or a lock prefix makes the opcode illegal.
    always_comb bad_op = !feat_en || lock;
endmodule

// File: rtl/popc_unit.sv
// Population count execution unit with one register stage.
// Masks the operand by size, counts its ones in an adder tree, computes the flags,
// and registers the result or the fault. Assumes a 64-bit datapath.
module popc_unit
    import popc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [1:0]        in_size,
    input  logic              in_feat_en,
    input  logic              in_lock,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_fault
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] masked;
    logic [CNT_W-1:0]  count;
    logic              bad_op;
    logic              src_zero;
    logic [FLAG_W-1:0] flags_nx;

    popc_mask #(.DATA_W(DATA_W)) u_mask (
        .src    (in_src),
        .size   (opsz_e'(in_size)),
        .masked (masked)
    );

    popc_tree #(.LEAVES(DATA_W), .CNT_W(CNT_W)) u_tree (
        .bits  (masked),
        .count (count)
    );

    popc_gate u_gate (
        .feat_en (in_feat_en),
        .lock    (in_lock),
        .bad_op  (bad_op)
    );

    // Purpose: zero flag straight from the operand; every other flag is forced clear.
    always_comb begin
        src_zero         = (masked == '0);
        flags_nx         = '0;
        flags_nx[FLG_ZF] = src_zero;
    end

    // Purpose: output register stage; results change only on a completed, legal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_fault  <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
        end else begin
            out_valid <= in_valid && !bad_op;
            out_fault <= in_valid && bad_op;
            if (in_valid && !bad_op) begin
                out_result <= DATA_W'(count);
                out_flags  <= flags_nx;
            end
        end
    end

    // R4: only the zero flag may be nonzero
    a_r4_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_flags & ~(FLAG_W'(1) << FLG_ZF)) == '0));
    // R5: the zero flag agrees with a zero count
    a_r5_zf_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flags[FLG_ZF] == (out_result == '0)));
    // R3: the count never exceeds the datapath width
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result <= DATA_W));
    // R8: a fault and a valid result never occur together
    a_r8_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));
    // R6 and R7: an illegal sampled operation faults on the next clock
    a_r7_fault_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!in_feat_en || in_lock)) |=> out_fault);
    // R11: an idle cycle yields no valid and no fault
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_fault));
    // R10: reset clears the handshake outputs
    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_fault));
endmodule

// File: tb/popc_unit_bench.sv
module popc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic [1:0]  in_size = 2'b10;
    logic        in_feat_en = 1'b1;
    logic        in_lock = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;
    logic        out_fault;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_res = '0;
    logic [5:0]  last_flg = '0;

    always #2.5 clk = ~clk;

    popc_unit u_popc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_size(in_size), .in_feat_en(in_feat_en), .in_lock(in_lock),
        .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags),
        .out_fault(out_fault)
    );

    function automatic logic [63:0] keep(input logic [63:0] s, input logic [1:0] z);
        case (z)
            2'b00:   return {48'h0, s[15:0]};
            2'b01:   return {32'h0, s[31:0]};
            default: return s;
        endcase
    endfunction

    function automatic logic [63:0] ones(input logic [63:0] s);
        logic [63:0] c = 0;
        for (int i = 0; i < 64; i++) c += 64'(s[i]);
        return c;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one operation (or idle) at the falling edge, check after the next rising edge.
    task automatic op(input logic v, input logic [63:0] s, input logic [1:0] z,
                      input logic fe, input logic lk, input string req);
        logic bad;
        logic [63:0] k;
        @(negedge clk);
        in_valid = v; in_src = s; in_size = z; in_feat_en = fe; in_lock = lk;
        @(posedge clk); #1;
        bad = !fe || lk;
        k = keep(s, z);
        if (v && !bad) begin
            last_res = ones(k);
            last_flg = (k == 0) ? 6'b001000 : 6'b000000;
        end
        chk({req, " valid"}, 64'(out_valid), 64'(v && !bad));
        chk({req, " fault"}, 64'(out_fault), 64'(v && bad));
        chk({req, " result"}, out_result, last_res);
        chk({req, " flags"}, 64'(out_flags), 64'(last_flg));
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset valid", 64'(out_valid), 0);
        chk("R10 reset fault", 64'(out_fault), 0);
        chk("R10 reset result", out_result, 0);
        chk("R10 reset flags", 64'(out_flags), 0);
        @(negedge clk); rst_n = 1'b1;

        op(1, {64{1'b1}}, 2'b10, 1, 0, "R3 max 64");
        op(1, 64'h0, 2'b10, 1, 0, "R5 zero src");
        op(1, 64'hFFFF_FFFF_FFFF_0000, 2'b00, 1, 0, "R2 16 upper ignored");
        op(1, 64'hFFFF_FFFF_0000_0000, 2'b01, 1, 0, "R2 32 upper ignored");
        op(1, 64'h8000_0000_0000_0001, 2'b11, 1, 0, "R2 rsvd as 64");
        op(1, 64'hF0F0, 2'b00, 1, 0, "R1 16 bit");
        op(1, 64'h1234_5678, 2'b01, 0, 0, "R6 feature off");
        op(1, 64'h1234_5678, 2'b01, 1, 1, "R7 lock");
        op(1, 64'h5, 2'b10, 0, 1, "R8 both faults");
        op(0, 64'hFFFF, 2'b10, 1, 0, "R11 idle");
        op(1, 64'h1, 2'b10, 1, 0, "R9 back to back a");
        op(1, 64'h3, 2'b10, 1, 0, "R9 back to back b");
        op(1, 64'h8000_0000_0000_0000, 2'b10, 1, 0, "R4 top bit");

        for (int n = 0; n < 3000; n++) begin
            logic [63:0] s;
            logic [3:0] r = 4'($urandom);
            s = {$urandom, $urandom};
            if (r == 0) s = s & {$urandom, $urandom} & {$urandom, $urandom};
            if (r == 1) s = s | {$urandom, $urandom} | {$urandom, $urandom};
            op(($urandom % 8) != 0, s, 2'($urandom),
               ($urandom % 10) != 0, ($urandom % 10) == 0, "R1 R9 random");
        end

        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(posedge clk); #1;
        chk("R10 mid reset valid", 64'(out_valid), 0);
        chk("R10 mid reset result", out_result, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule